// File: doc/BRIEF.md
# Interrupt Code-Segment Context Controller

This block keeps track of which 64-Kbyte code segment a CPU is executing from. The program address is 22 bits wide: a 6-bit segment value sits above a 16-bit program counter. The block holds two segment registers. The code segment register follows far calls, far returns and far jumps. The interrupt segment register names the segment that holds the service routines. The block drives the upper address bits from whichever of the two is active.

On subroutine and interrupt events, the block steps through the stack traffic one byte per cycle over a single-port push/pop interface. The bytes are the program counter, the flags and, where the frame calls for it, the old code segment.

A one-bit frame-mode setting selects how an interrupt is entered:
- **Short frame.** The service routine runs from the interrupt segment register. The code segment register is left alone, so the frame is small.
- **Long frame.** The old code segment is stacked and then reloaded from the interrupt segment register. This lets the service routine jump to any segment.

The block records, per nesting level, which kind of frame was built. A return therefore always unwinds the right number of bytes, even if the mode has changed in between. Data-space paging and the stack pointer are outside the block. The service routine shares the main program's stack.

Top module: `seg_ctx_ctrl`

## Requirements
- R1: After a synchronous reset, the code segment, the interrupt segment, the frame mode, `busy_o`, `servicing_o` and `seg_o` are all 0, and no stack push or pop is driven.
- R2: `seg_o` equals the interrupt segment register while `servicing_o` is high, and equals the code segment register otherwise. A write on `isr_wr_i` loads the interrupt segment register on the next edge.
- R3: A write on `mode_wr_i` stores `mode_wdata_i` as the frame mode, shown on `frame_mode_o`. 0 selects short frames and 1 selects long frames.
- R4: Short-frame interrupt entry (mode 0), with the event sampled in cycle 0:
  - Cycles 1 to 3 push, in order, PC[7:0], PC[15:8] and the flags, with `busy_o` high.
  - `servicing_o` goes high in cycle 4.
  - The code segment register is unchanged.
- R5: Long-frame interrupt entry (mode 1):
  - Cycles 1 to 4 push PC[7:0], PC[15:8], the flags, and then the old code segment, zero-extended to 8 bits.
  - From cycle 5, the code segment register holds the interrupt segment value.
  - `servicing_o` is not raised by this entry.
- R6: Interrupt return pops in the reverse of the push order.
  - A long frame first restores the code segment register from the popped byte.
  - When the sequence ends, `ret_pc_o` and `ret_flags_o` hold the popped values, and `ret_valid_o` pulses for one cycle.
- R7: Each nesting level records whether its frame was short or long. An interrupt return pops 3 or 4 bytes according to that record, not according to the current mode.
- R8: Up to 8 interrupt levels nest.
  - `servicing_o` stays high until the outermost short frame has returned.
  - An interrupt request at 8 levels is ignored.
  - An interrupt return with no level open is ignored.
- R9: A far call pushes PC[7:0], PC[15:8] and the code segment, then loads the code segment from `tgt_seg_i`. A far return pops the segment, PC[15:8] and PC[7:0], and restores the code segment.
- R10: A near call pushes only PC[7:0] and PC[15:8]. A near return pops only those two bytes. Neither changes the code segment.
- R11: A far jump loads `tgt_seg_i` into the code segment register on the next edge, with no stack traffic. While `servicing_o` is high, `seg_o` does not follow it.
- R12: Events are ignored while `busy_o` is high. When several events are requested in one idle cycle, only one is accepted, in this priority order: interrupt, interrupt return, far call, far return, far jump, near call, near return.
- R13: At most one of `stk_push_o` and `stk_pop_o` is high in a cycle, and every busy cycle moves exactly one byte. `stk_rdata_i` must present the top of the stack in the same cycle that `stk_pop_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_i | input | 1 | Frame-mode write strobe |
| mode_wdata_i | input | 1 | Frame-mode value (1 = long frame) |
| isr_wr_i | input | 1 | Interrupt segment register write strobe |
| isr_wdata_i | input | SEG_W | Interrupt segment write value |
| irq_take_i | input | 1 | Interrupt entry request |
| irq_ret_i | input | 1 | Interrupt return request |
| far_call_i | input | 1 | Far call request |
| far_ret_i | input | 1 | Far return request |
| far_jmp_i | input | 1 | Far jump request |
| near_call_i | input | 1 | Near call request |
| near_ret_i | input | 1 | Near return request |
| tgt_seg_i | input | SEG_W | Target segment for far call or far jump |
| pc_i | input | 16 | Program counter to stack |
| flags_i | input | 8 | Flags to stack |
| stk_rdata_i | input | 8 | Top-of-stack byte |
| stk_push_o | output | 1 | Push strobe |
| stk_pop_o | output | 1 | Pop strobe |
| stk_wdata_o | output | 8 | Byte to push |
| busy_o | output | 1 | Stack sequence in progress |
| seg_o | output | SEG_W | Upper program address bits |
| csr_o | output | SEG_W | Code segment register |
| isr_o | output | SEG_W | Interrupt segment register |
| frame_mode_o | output | 1 | Current frame mode |
| servicing_o | output | 1 | A short-frame service routine is open |
| ret_pc_o | output | 16 | Program counter restored by the last return |
| ret_flags_o | output | 8 | Flags restored by the last interrupt return |
| ret_valid_o | output | 1 | One-cycle pulse when a return completes |

## Verification
Results fall due at different times:
- Register writes and far jumps take effect one cycle after the request is sampled.
- A stack sequence of n bytes keeps `busy_o` high for cycles 1 to n.
- The segment update, the change of `servicing_o`, and the return values with their `ret_valid_o` pulse appear in cycle n+1.

The bench drives each request just after a falling edge and counts busy cycles at falling edges. It checks every result at the first falling edge where `busy_o` is low, which is exactly cycle n+1. One directed case also samples `servicing_o` inside the busy window, to confirm that it has not risen early.

// File: rtl/seg_ctx_pkg.sv
package seg_ctx_pkg;
  localparam int PC_W   = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_NONE, OP_IRQ, OP_IRET, OP_FCALL, OP_FRET, OP_NCALL, OP_NRET
  } op_e;

  typedef enum logic [1:0] {RL_PCL, RL_PCH, RL_FLG, RL_SEG} role_e;

  // number of stack bytes moved by an operation
  function automatic logic [2:0] seq_len(op_e op, logic lng);
    case (op)
      OP_IRQ, OP_IRET:   seq_len = lng ? 3'd4 : 3'd3;
      OP_FCALL, OP_FRET: seq_len = 3'd3;
      OP_NCALL, OP_NRET: seq_len = 3'd2;
      default:           seq_len = 3'd0;
    endcase
  endfunction

  function automatic logic is_pop(op_e op);
    return (op == OP_IRET) || (op == OP_FRET) || (op == OP_NRET);
  endfunction

  // byte role at position idx of the push order
  function automatic role_e push_role(op_e op, logic [1:0] idx);
    case (idx)
      2'd0:    push_role = RL_PCL;
      2'd1:    push_role = RL_PCH;
      2'd2:    push_role = (op == OP_FCALL || op == OP_FRET) ? RL_SEG : RL_FLG;
      default: push_role = RL_SEG;
    endcase
  endfunction

  // pops walk the push order backwards
  function automatic role_e step_role(op_e op, logic lng, logic [1:0] step);
    logic [2:0] rev;
    rev = seq_len(op, lng) - 3'd1 - {1'b0, step};
    return is_pop(op) ? push_role(op, rev[1:0]) : push_role(op, step);
  endfunction
endpackage

// File: rtl/seg_ctx_frames.sv
module seg_ctx_frames #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic push_i,
  input  logic kind_i,
  input  logic pop_i,
  output logic top_kind_o,
  output logic empty_o,
  output logic full_o,
  output logic servicing_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] kind_q;   // 1 = long frame at that level
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] short_open;
  logic [CNT_W-1:0] top_idx;

  assign top_idx = cnt_q - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= '0;
      cnt_q  <= '0;
    end else if (push_i && !full_o) begin
      kind_q[cnt_q[IDX_W-1:0]] <= kind_i;
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= top_idx;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
      assign short_open[i] = (CNT_W'(i) < cnt_q) && !kind_q[i];
    end
  endgenerate

  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CNT_W'(DEPTH));
  assign top_kind_o  = kind_q[top_idx[IDX_W-1:0]];
  assign servicing_o = |short_open;
endmodule

// File: rtl/seg_ctx_seq.sv
module seg_ctx_seq
  import seg_ctx_pkg::*;
#(
  parameter int SEG_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic              long_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [BYTE_W-1:0] flags_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [BYTE_W-1:0] stk_rdata_i,
  output logic              stk_push_o,
  output logic              stk_pop_o,
  output logic [BYTE_W-1:0] stk_wdata_o,
  output logic              busy_o,
  output logic              last_o,
  output op_e               op_o,
  output logic              long_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic [PC_W-1:0]   ret_pc_o,
  output logic [BYTE_W-1:0] ret_flags_o,
  output logic              ret_valid_o
);
  logic              busy_q, long_q, rv_q;
  logic [1:0]        step_q;
  op_e               op_q;
  logic [PC_W-1:0]   pc_q;
  logic [BYTE_W-1:0] flg_q;
  logic [SEG_W-1:0]  seg_q;
  role_e             role;
  logic              popping;

  assign role    = step_role(op_q, long_q, step_q);
  assign popping = is_pop(op_q);
  assign last_o  = busy_q && ({1'b0, step_q} == seq_len(op_q, long_q) - 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      step_q <= '0;
      op_q   <= OP_NONE;
      long_q <= 1'b0;
      pc_q   <= '0;
      flg_q  <= '0;
      seg_q  <= '0;
      rv_q   <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          step_q <= '0;
          op_q   <= op_i;
          long_q <= long_i;
          pc_q   <= pc_i;
          flg_q  <= flags_i;
          seg_q  <= seg_i;
        end
      end else begin
        if (popping) begin
          case (role)
            RL_PCL:  pc_q[7:0]  <= stk_rdata_i;
            RL_PCH:  pc_q[15:8] <= stk_rdata_i;
            RL_FLG:  flg_q      <= stk_rdata_i;
            default: seg_q      <= stk_rdata_i[SEG_W-1:0];
          endcase
        end
        step_q <= step_q + 2'd1;
        if (last_o) begin
          busy_q <= 1'b0;
          rv_q   <= popping;
        end
      end
    end
  end

  always_comb begin
    case (role)
      RL_PCL:  stk_wdata_o = pc_q[7:0];
      RL_PCH:  stk_wdata_o = pc_q[15:8];
      RL_FLG:  stk_wdata_o = flg_q;
      default: stk_wdata_o = BYTE_W'(seg_q);
    endcase
  end

  assign stk_push_o  = busy_q && !popping;
  assign stk_pop_o   = busy_q && popping;
  assign busy_o      = busy_q;
  assign op_o        = op_q;
  assign long_o      = long_q;
  assign seg_o       = seg_q;
  assign ret_pc_o    = pc_q;
  assign ret_flags_o = flg_q;
  assign ret_valid_o = rv_q;
endmodule

// File: rtl/seg_ctx_ctrl.sv
module seg_ctx_ctrl
  import seg_ctx_pkg::*;
#(
  parameter int SEG_W = 6,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr_i,
  input  logic              mode_wdata_i,
  input  logic              isr_wr_i,
  input  logic [SEG_W-1:0]  isr_wdata_i,
  input  logic              irq_take_i,
  input  logic              irq_ret_i,
  input  logic              far_call_i,
  input  logic              far_ret_i,
  input  logic              far_jmp_i,
  input  logic              near_call_i,
  input  logic              near_ret_i,
  input  logic [SEG_W-1:0]  tgt_seg_i,
  input  logic [15:0]       pc_i,
  input  logic [7:0]        flags_i,
  input  logic [7:0]        stk_rdata_i,
  output logic              stk_push_o,
  output logic              stk_pop_o,
  output logic [7:0]        stk_wdata_o,
  output logic              busy_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic [SEG_W-1:0]  csr_o,
  output logic [SEG_W-1:0]  isr_o,
  output logic              frame_mode_o,
  output logic              servicing_o,
  output logic [15:0]       ret_pc_o,
  output logic [7:0]        ret_flags_o,
  output logic              ret_valid_o
);
  logic [SEG_W-1:0] csr_q, isr_q, tgt_q;
  logic             mode_q;
  op_e              sel_op, cur_op;
  logic             sel_long, jmp_go, start;
  logic             top_kind, lvl_empty, lvl_full;
  logic             last, cur_long;
  logic [SEG_W-1:0] seq_seg;

  // one event per idle cycle, fixed priority
  always_comb begin
    sel_op = OP_NONE;
    jmp_go = 1'b0;
    if (!busy_o) begin
      if (irq_take_i && !lvl_full)      sel_op = OP_IRQ;
      else if (irq_ret_i && !lvl_empty) sel_op = OP_IRET;
      else if (far_call_i)              sel_op = OP_FCALL;
      else if (far_ret_i)               sel_op = OP_FRET;
      else if (far_jmp_i)               jmp_go = 1'b1;
      else if (near_call_i)             sel_op = OP_NCALL;
      else if (near_ret_i)              sel_op = OP_NRET;
    end
    case (sel_op)
      OP_IRQ:  sel_long = mode_q;
      OP_IRET: sel_long = top_kind;
      default: sel_long = 1'b0;
    endcase
  end

  assign start = (sel_op != OP_NONE);

  seg_ctx_seq #(.SEG_W(SEG_W)) i_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .op_i        (sel_op),
    .long_i      (sel_long),
    .pc_i        (pc_i),
    .flags_i     (flags_i),
    .seg_i       (csr_q),
    .stk_rdata_i (stk_rdata_i),
    .stk_push_o  (stk_push_o),
    .stk_pop_o   (stk_pop_o),
    .stk_wdata_o (stk_wdata_o),
    .busy_o      (busy_o),
    .last_o      (last),
    .op_o        (cur_op),
    .long_o      (cur_long),
    .seg_o       (seq_seg),
    .ret_pc_o    (ret_pc_o),
    .ret_flags_o (ret_flags_o),
    .ret_valid_o (ret_valid_o)
  );

  seg_ctx_frames #(.DEPTH(DEPTH)) i_frames (
    .clk         (clk),
    .rst         (rst),
    .push_i      (last && cur_op == OP_IRQ),
    .kind_i      (cur_long),
    .pop_i       (last && cur_op == OP_IRET),
    .top_kind_o  (top_kind),
    .empty_o     (lvl_empty),
    .full_o      (lvl_full),
    .servicing_o (servicing_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q  <= '0;
      isr_q  <= '0;
      tgt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (isr_wr_i)  isr_q  <= isr_wdata_i;
      if (mode_wr_i) mode_q <= mode_wdata_i;
      if (start)     tgt_q  <= tgt_seg_i;
      if (jmp_go) begin
        csr_q <= tgt_seg_i;
      end else if (last) begin
        case (cur_op)
          OP_FCALL: csr_q <= tgt_q;
          OP_FRET:  csr_q <= seq_seg;
          OP_IRQ:   if (cur_long) csr_q <= isr_q;
          OP_IRET:  if (cur_long) csr_q <= seq_seg;
          default:  ;
        endcase
      end
    end
  end

  assign seg_o        = servicing_o ? isr_q : csr_q;
  assign csr_o        = csr_q;
  assign isr_o        = isr_q;
  assign frame_mode_o = mode_q;
endmodule

// File: rtl/seg_ctx_chk.sv
module seg_ctx_chk #(
  parameter int SEG_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             busy_o,
  input logic             stk_push_o,
  input logic             stk_pop_o,
  input logic             ret_valid_o,
  input logic             servicing_o,
  input logic [SEG_W-1:0] csr_o,
  input logic [SEG_W-1:0] seg_o,
  input logic             isr_wr_i,
  input logic             irq_take_i,
  input logic             irq_ret_i,
  input logic             far_call_i,
  input logic             far_ret_i,
  input logic             far_jmp_i,
  input logic             near_call_i,
  input logic             near_ret_i,
  input logic [SEG_W-1:0] tgt_seg_i
);
  logic any_ev;
  assign any_ev = irq_take_i || irq_ret_i || far_call_i || far_ret_i ||
                  far_jmp_i || near_call_i || near_ret_i;

  p_one_dir_r13: assert property (@(posedge clk) disable iff (rst)
    !(stk_push_o && stk_pop_o));

  p_busy_moves_r13: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (stk_push_o || stk_pop_o));

  p_jump_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && far_jmp_i && !irq_take_i && !irq_ret_i && !far_call_i && !far_ret_i)
    |=> (csr_o == $past(tgt_seg_i)));

  p_short_keeps_csr_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(servicing_o) |-> $stable(csr_o));

  p_ret_idle_r6: assert property (@(posedge clk) disable iff (rst)
    ret_valid_o |-> !busy_o);

  p_idle_seg_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !any_ev && !isr_wr_i) |=> $stable(seg_o));
endmodule

bind seg_ctx_ctrl seg_ctx_chk #(.SEG_W(SEG_W)) i_seg_ctx_chk (
  .clk         (clk),
  .rst         (rst),
  .busy_o      (busy_o),
  .stk_push_o  (stk_push_o),
  .stk_pop_o   (stk_pop_o),
  .ret_valid_o (ret_valid_o),
  .servicing_o (servicing_o),
  .csr_o       (csr_o),
  .seg_o       (seg_o),
  .isr_wr_i    (isr_wr_i),
  .irq_take_i  (irq_take_i),
  .irq_ret_i   (irq_ret_i),
  .far_call_i  (far_call_i),
  .far_ret_i   (far_ret_i),
  .far_jmp_i   (far_jmp_i),
  .near_call_i (near_call_i),
  .near_ret_i  (near_ret_i),
  .tgt_seg_i   (tgt_seg_i)
);

// File: tb/test_seg_ctx_ctrl.sv
module test_seg_ctx_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 5000;
  localparam int NV         = 18;

  // event codes used by the table
  localparam logic [3:0] E_MODE = 4'd0, E_ISRW = 4'd1, E_IRQ = 4'd2, E_IRET = 4'd3,
                         E_FCALL = 4'd4, E_FRET = 4'd5, E_NCALL = 4'd6, E_NRET = 4'd7,
                         E_FJMP = 4'd8;

  typedef struct packed {
    logic [3:0]  ev;
    logic [15:0] pc;
    logic [7:0]  flg;
    logic [5:0]  tgt;
    logic [2:0]  n;
    logic [5:0]  seg;
    logic [5:0]  csr;
    logic        serv;
    logic [7:0]  top;
    logic [15:0] rpc;
    logic [7:0]  rflg;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{E_ISRW,  16'h0000, 8'h00, 6'h2A, 3'd0, 6'h00, 6'h00, 1'b0, 8'h00, 16'h0000, 8'h00},
    '{E_FJMP,  16'h0000, 8'h00, 6'h05, 3'd0, 6'h05, 6'h05, 1'b0, 8'h00, 16'h0000, 8'h00},
    '{E_FCALL, 16'h1234, 8'h00, 6'h11, 3'd3, 6'h11, 6'h11, 1'b0, 8'h05, 16'h0000, 8'h00},
    '{E_NCALL, 16'hABCD, 8'h00, 6'h00, 3'd2, 6'h11, 6'h11, 1'b0, 8'hAB, 16'h0000, 8'h00},
    '{E_IRQ,   16'h4000, 8'h81, 6'h00, 3'd3, 6'h2A, 6'h11, 1'b1, 8'h81, 16'h0000, 8'h00},
    '{E_FJMP,  16'h0000, 8'h00, 6'h22, 3'd0, 6'h2A, 6'h22, 1'b1, 8'h00, 16'h0000, 8'h00},
    '{E_IRQ,   16'h4100, 8'h42, 6'h00, 3'd3, 6'h2A, 6'h22, 1'b1, 8'h42, 16'h0000, 8'h00},
    '{E_IRET,  16'h0000, 8'h00, 6'h00, 3'd3, 6'h2A, 6'h22, 1'b1, 8'h00, 16'h4100, 8'h42},
    '{E_MODE,  16'h0000, 8'h00, 6'h01, 3'd0, 6'h2A, 6'h22, 1'b1, 8'h00, 16'h0000, 8'h00},
    '{E_IRET,  16'h0000, 8'h00, 6'h00, 3'd3, 6'h22, 6'h22, 1'b0, 8'h00, 16'h4000, 8'h81},
    '{E_IRQ,   16'h5000, 8'h10, 6'h00, 3'd4, 6'h2A, 6'h2A, 1'b0, 8'h22, 16'h0000, 8'h00},
    '{E_MODE,  16'h0000, 8'h00, 6'h00, 3'd0, 6'h2A, 6'h2A, 1'b0, 8'h00, 16'h0000, 8'h00},
    '{E_IRQ,   16'h5100, 8'h20, 6'h00, 3'd3, 6'h2A, 6'h2A, 1'b1, 8'h20, 16'h0000, 8'h00},
    '{E_FJMP,  16'h0000, 8'h00, 6'h33, 3'd0, 6'h2A, 6'h33, 1'b1, 8'h00, 16'h0000, 8'h00},
    '{E_IRET,  16'h0000, 8'h00, 6'h00, 3'd3, 6'h33, 6'h33, 1'b0, 8'h00, 16'h5100, 8'h20},
    '{E_IRET,  16'h0000, 8'h00, 6'h00, 3'd4, 6'h22, 6'h22, 1'b0, 8'h00, 16'h5000, 8'h10},
    '{E_NRET,  16'h0000, 8'h00, 6'h00, 3'd2, 6'h22, 6'h22, 1'b0, 8'h00, 16'hABCD, 8'h00},
    '{E_FRET,  16'h0000, 8'h00, 6'h00, 3'd3, 6'h05, 6'h05, 1'b0, 8'h00, 16'h1234, 8'h00}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic mode_wr_i = 0, mode_wdata_i = 0, isr_wr_i = 0;
  logic [5:0] isr_wdata_i = '0, tgt_seg_i = '0;
  logic irq_take_i = 0, irq_ret_i = 0, far_call_i = 0, far_ret_i = 0;
  logic far_jmp_i = 0, near_call_i = 0, near_ret_i = 0;
  logic [15:0] pc_i = '0;
  logic [7:0]  flags_i = '0;
  logic [7:0]  stk_rdata_i, stk_wdata_o;
  logic stk_push_o, stk_pop_o, busy_o, frame_mode_o, servicing_o, ret_valid_o;
  logic [5:0]  seg_o, csr_o, isr_o;
  logic [15:0] ret_pc_o;
  logic [7:0]  ret_flags_o;

  int errors = 0, checks = 0;

  // stack model: LIFO, top byte visible combinationally
  logic [7:0] mem [64];
  logic [6:0] sp;
  assign stk_rdata_i = (sp != 0) ? mem[sp[5:0] - 6'd1] : 8'h00;
  always @(posedge clk) begin
    if (rst) sp <= '0;
    else if (stk_push_o) begin mem[sp[5:0]] <= stk_wdata_o; sp <= sp + 7'd1; end
    else if (stk_pop_o) sp <= sp - 7'd1;
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_ctx_ctrl i_seg_ctx_ctrl (.*);

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_ev();
    mode_wr_i = 0; isr_wr_i = 0; irq_take_i = 0; irq_ret_i = 0; far_call_i = 0;
    far_ret_i = 0; far_jmp_i = 0; near_call_i = 0; near_ret_i = 0;
  endtask

  task automatic set_ev(input logic [3:0] ev, input logic [15:0] pc, input logic [7:0] fl,
                        input logic [5:0] tg);
    pc_i = pc; flags_i = fl; tgt_seg_i = tg; isr_wdata_i = tg; mode_wdata_i = tg[0];
    case (ev)
      E_MODE:  mode_wr_i = 1;
      E_ISRW:  isr_wr_i = 1;
      E_IRQ:   irq_take_i = 1;
      E_IRET:  irq_ret_i = 1;
      E_FCALL: far_call_i = 1;
      E_FRET:  far_ret_i = 1;
      E_NCALL: near_call_i = 1;
      E_NRET:  near_ret_i = 1;
      default: far_jmp_i = 1;
    endcase
  endtask

  // drive for one cycle, then count busy cycles; returns at cycle n+1
  task automatic run_ev(input logic [3:0] ev, input logic [15:0] pc, input logic [7:0] fl,
                        input logic [5:0] tg, output int n, output logic rv);
    @(negedge clk); set_ev(ev, pc, fl, tg);
    @(negedge clk); clear_ev();
    n = 0;
    while (busy_o && n < 10) begin n++; @(negedge clk); end
    rv = ret_valid_o;
  endtask

  function automatic string req_of(input logic [3:0] ev);
    case (ev)
      E_MODE:  return "R3";
      E_ISRW:  return "R2";
      E_IRQ:   return "R4/R5";
      E_IRET:  return "R6/R7";
      E_FCALL, E_FRET: return "R9";
      E_NCALL, E_NRET: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic rv;
    logic [6:0] sp0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", "seg", 32'(seg_o), 0);
    check("R1", "busy", 32'(busy_o), 0);
    check("R1", "servicing", 32'(servicing_o), 0);
    check("R1", "mode", 32'(frame_mode_o), 0);
    check("R1", "csr/isr", {csr_o, isr_o}, 0);
    check("R1", "stack strobes", {stk_push_o, stk_pop_o}, 0);

    foreach (TBL[i]) begin
      sp0 = sp;
      run_ev(TBL[i].ev, TBL[i].pc, TBL[i].flg, TBL[i].tgt, n, rv);
      check(req_of(TBL[i].ev), $sformatf("row %0d bytes", i), 32'(n), 32'(TBL[i].n));
      check("R13", $sformatf("row %0d sp move", i),
            32'(sp > sp0 ? sp - sp0 : sp0 - sp), 32'(TBL[i].n));
      check("R2", $sformatf("row %0d seg", i), 32'(seg_o), 32'(TBL[i].seg));
      check(req_of(TBL[i].ev), $sformatf("row %0d csr", i), 32'(csr_o), 32'(TBL[i].csr));
      check("R8", $sformatf("row %0d servicing", i), 32'(servicing_o), 32'(TBL[i].serv));
      if (TBL[i].ev == E_MODE)
        check("R3", "mode out", 32'(frame_mode_o), 32'(TBL[i].tgt[0]));
      if (TBL[i].ev inside {E_IRQ, E_FCALL, E_NCALL})
        check(req_of(TBL[i].ev), $sformatf("row %0d top byte", i),
              32'(mem[sp[5:0] - 6'd1]), 32'(TBL[i].top));
      if (TBL[i].ev inside {E_IRET, E_FRET, E_NRET}) begin
        check("R6", $sformatf("row %0d ret pc", i), 32'(ret_pc_o), 32'(TBL[i].rpc));
        check("R6", $sformatf("row %0d ret valid", i), 32'(rv), 1);
        if (TBL[i].ev == E_IRET)
          check("R6", $sformatf("row %0d ret flags", i), 32'(ret_flags_o), 32'(TBL[i].rflg));
      end
    end
    check("R13", "stack balanced", 32'(sp), 0);

    // R12: far jump while busy is ignored; R4: servicing not yet high in cycle 1
    @(negedge clk); set_ev(E_IRQ, 16'h0102, 8'h03, 6'h00);
    @(negedge clk); clear_ev(); set_ev(E_FJMP, 16'h0, 8'h0, 6'h3F);
    check("R4", "servicing during push", 32'(servicing_o), 0);
    @(negedge clk); clear_ev();
    while (busy_o) @(negedge clk);
    check("R12", "jump while busy ignored", 32'(csr_o), 32'h05);
    check("R2", "seg from isr", 32'(seg_o), 32'h2A);
    run_ev(E_IRET, 0, 0, 0, n, rv);
    check("R6", "iret pc", 32'(ret_pc_o), 32'h0102);

    // R12 priority: interrupt wins over far jump in the same cycle
    @(negedge clk); set_ev(E_IRQ, 16'h0304, 8'h00, 6'h00); far_jmp_i = 1; tgt_seg_i = 6'h3E;
    @(negedge clk); clear_ev();
    n = 0; while (busy_o && n < 10) begin n++; @(negedge clk); end
    check("R12", "priority bytes", 32'(n), 3);
    check("R12", "priority csr", 32'(csr_o), 32'h05);
    run_ev(E_IRET, 0, 0, 0, n, rv);

    // R8: return with no open level ignored
    sp0 = sp;
    run_ev(E_IRET, 0, 0, 0, n, rv);
    check("R8", "empty iret bytes", 32'(n), 0);
    check("R8", "empty iret sp", 32'(sp), 32'(sp0));
    check("R8", "empty iret valid", 32'(rv), 0);

    // R8: eight levels nest, ninth refused, servicing holds to outermost
    for (int k = 0; k < 8; k++) begin
      run_ev(E_IRQ, 16'h6000 + 16'(k), 8'(k), 0, n, rv);
      check("R8", $sformatf("nest %0d bytes", k), 32'(n), 3);
    end
    sp0 = sp;
    run_ev(E_IRQ, 16'h7000, 0, 0, n, rv);
    check("R8", "ninth refused", 32'(n), 0);
    check("R8", "ninth sp", 32'(sp), 32'(sp0));
    for (int k = 7; k >= 0; k--) begin
      run_ev(E_IRET, 0, 0, 0, n, rv);
      check("R8", $sformatf("unwind %0d pc", k), 32'(ret_pc_o), 32'h6000 + 32'(k));
      check("R8", $sformatf("unwind %0d servicing", k), 32'(servicing_o), (k == 0) ? 0 : 1);
    end

    // R1: reset in the middle of a sequence
    @(negedge clk); set_ev(E_IRQ, 16'h0A0B, 8'h00, 6'h00);
    @(negedge clk); clear_ev(); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1", "mid reset busy", 32'(busy_o), 0);
    check("R1", "mid reset seg/csr", {seg_o, csr_o}, 0);
    check("R1", "mid reset servicing", 32'(servicing_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule